// File: doc/BRIEF.md
# Cache Miss Tracking Entry

One slot of a non-blocking cache's miss tracker. It is allocated when a miss to a new block is detected. It holds the block-aligned address, a few attribute bits, and an ordered list of the requests waiting on that block (targets). While the fill request is outstanding, later requests to the same block are appended to this list.

A request that needs write permission can arrive after the fill has already been issued without a promise of ownership. Such a request goes into a second, deferred list. After the fill returns and the main list has drained, the deferred requests are promoted to the main list in their arrival order, ready to be issued again.

One flag records that the expected fill will arrive owned. The same flag also means that the fill will arrive writable. Snoops that hit while data is outstanding are remembered so that the cache can invalidate or downgrade the block after the fill.

Top module: `miss_track_entry`

## Requirements
- R1: After reset the entry is invalid, both lists are empty, and every flag, `stall_o` and `flag_err_o` read 0.
- R2: An allocate on a free entry does the following, all visible one cycle later:
  - It records the address and the attribute bits (uncacheable, secure, forward, allocate-on-fill).
  - It stores the supplied target as the only target, with `in_service_o`=0.
  - It sets `need_wr_o` and `has_upg_o` from that target.
  - Source encoding: 0 = CPU, 1 = snoop, 2 = prefetcher.
- R3: Targets accepted into the main list leave it in arrival order. Each pop removes the head. Accepting a target ORs its need-write and upgrade bits into `need_wr_o` and `has_upg_o`.
- R4: A new target goes to the deferred list exactly when the entry is in service, the target needs write access, and `pend_mod_o` is 0. Any other target goes to the main list.
- R5: Marking the entry in service sets `in_service_o`. It loads `pend_mod_o` with the OR of `need_wr_o` and the pending-modified input.
- R6: A snooped invalidate sets `post_inv_o` and a snooped read sets `post_dg_o`, but only while in service. Otherwise snoops are ignored. A fill clears both flags.
- R7: `flag_err_o` is 1 in any cycle where `flag_rd_i` is 1 and the entry is not in service, and 0 otherwise.
- R8: `num_tgt_o` equals `main_cnt_o` plus `def_cnt_o`.
- R9: `fwd_nores_o` is 1 exactly when the entry holds one target in total, in the main list, from the CPU (source 0), and not needing a response.
- R10: A promote is ignored unless the entry is out of service, the main list is empty, and the deferred list is non-empty. When accepted, it does the following:
  - It moves all deferred targets to the main list in their original order.
  - It recomputes `need_wr_o` and `has_upg_o` from the moved targets.
- R11: An add to a full destination list (depth 8) raises `stall_o` in that cycle and changes no state.
- R12: The downstream-pending flag is set by `dpend_set_i` and cleared by `dpend_clr_i`. A deallocate returns the entry to its reset state.
- R13: A fill response while in service clears `in_service_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Allocate strobe (uses the tgt_* fields as the first target) |
| alloc_addr_i | input | ADDR_W | Block-aligned miss address |
| alloc_uncache_i | input | 1 | Uncacheable attribute |
| alloc_secure_i | input | 1 | Secure-space attribute |
| alloc_fwd_i | input | 1 | Forward-only attribute |
| alloc_fill_i | input | 1 | Allocate-on-fill attribute |
| tgt_add_i | input | 1 | Add-target strobe |
| tgt_src_i | input | 2 | Target source: 0 CPU, 1 snoop, 2 prefetcher |
| tgt_order_i | input | ORD_W | Global order number |
| tgt_ready_i | input | TIME_W | Ready time |
| tgt_marked_i | input | 1 | Target marked an upstream entry downstream-pending |
| tgt_need_wr_i | input | 1 | Target needs write access |
| tgt_upgrade_i | input | 1 | Target is an upgrade |
| tgt_need_resp_i | input | 1 | Target needs a response |
| svc_i | input | 1 | Mark-in-service strobe |
| svc_pmod_i | input | 1 | Fill is promised owned/writable |
| fill_i | input | 1 | Fill response strobe |
| snp_inv_i | input | 1 | Snooped invalidate |
| snp_rd_i | input | 1 | Snooped read |
| dpend_set_i | input | 1 | Set downstream-pending |
| dpend_clr_i | input | 1 | Clear downstream-pending |
| pop_i | input | 1 | Pop head target |
| promote_i | input | 1 | Promote deferred targets |
| dealloc_i | input | 1 | Deallocate strobe |
| flag_rd_i | input | 1 | Consumer reads the in-service-only flags |
| valid_o | output | 1 | Entry allocated |
| addr_o | output | ADDR_W | Stored address |
| uncache_o | output | 1 | Uncacheable attribute |
| secure_o | output | 1 | Secure attribute |
| fwd_o | output | 1 | Forward attribute |
| fill_alloc_o | output | 1 | Allocate-on-fill attribute |
| in_service_o | output | 1 | Fill request outstanding |
| dpend_o | output | 1 | Downstream-pending flag |
| need_wr_o | output | 1 | Main list needs write access |
| has_upg_o | output | 1 | Main list holds an upgrade |
| pend_mod_o | output | 1 | Fill expected owned and writable |
| post_inv_o | output | 1 | Invalidate snooped while outstanding |
| post_dg_o | output | 1 | Read snooped while outstanding |
| flag_err_o | output | 1 | Flags read while not in service |
| stall_o | output | 1 | Add refused, destination full |
| main_cnt_o | output | CW | Main list occupancy |
| def_cnt_o | output | CW | Deferred list occupancy |
| num_tgt_o | output | CW+1 | Total targets |
| fwd_nores_o | output | 1 | Single CPU target needing no response |
| head_src_o | output | 2 | Head target source |
| head_order_o | output | ORD_W | Head target order |
| head_ready_o | output | TIME_W | Head target ready time |
| head_marked_o | output | 1 | Head target marked bit |
| head_need_wr_o | output | 1 | Head target needs write |

## Verification
The combinational results, `stall_o` and `flag_err_o`, depend only on the strobes of the current cycle and the current state. The bench samples them one time unit after driving the inputs, before the clock edge that would consume them. Every other result comes from a register and shows one edge after its strobe. The bench drives on the falling edge and checks at the next falling edge, after exactly one rising edge.

Target order is checked through a scoreboard. The bench predicts which list each target enters. At each pop it compares `head_order_o` against the front of its predicted queue. On a promote it appends its deferred queue to its main queue.

// File: rtl/miss_pkg.sv
package miss_pkg;
  parameter int ORD_W  = 16;
  parameter int TIME_W = 16;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_SNOOP = 2'd1,
    SRC_PREF  = 2'd2
  } tgt_src_e;

  typedef struct packed {
    tgt_src_e            src;
    logic [ORD_W-1:0]    order;
    logic [TIME_W-1:0]   ready;
    logic                marked;
    logic                need_wr;
    logic                upgrade;
    logic                need_resp;
  } tgt_t;

  typedef struct packed {
    logic valid;
    logic in_service;
    logic uncache;
    logic secure;
    logic fwd;
    logic fill_alloc;
    logic dpend;
    logic need_wr;
    logic has_upg;
    logic pend_mod;
    logic post_inv;
    logic post_dg;
  } entry_flags_t;
endpackage

// File: rtl/miss_tgt_fifo.sv
module miss_tgt_fifo
  import miss_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  tgt_t          push_d_i,
  input  logic          pop_i,
  input  logic          load_i,
  input  tgt_t          load_arr_i [DEPTH],
  input  logic [CW-1:0] load_cnt_i,
  output tgt_t          arr_o [DEPTH],
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  tgt_t          arr_q [DEPTH];
  tgt_t          arr_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign arr_o   = arr_q;

  always_comb begin
    arr_n = arr_q;
    cnt_n = cnt_q;
    if (flush_i) begin
      cnt_n = '0;
      if (push_i) begin
        arr_n[0] = push_d_i;
        cnt_n    = CW'(1);
      end
    end else if (load_i) begin
      arr_n = load_arr_i;
      cnt_n = load_cnt_i;
    end else if (pop_i && !empty_o) begin
      for (int i = 0; i < DEPTH - 1; i++) arr_n[i] = arr_q[i+1];
      cnt_n = cnt_q - CW'(1);
    end else if (push_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt_q == CW'(i)) arr_n[i] = push_d_i;
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // storage needs no reset: occupancy alone qualifies it
  always_ff @(posedge clk) begin
    arr_q <= arr_n;
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_full_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !flush_i && !load_i && !pop_i) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/miss_flag_ctl.sv
module miss_flag_ctl
  import miss_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dealloc_i,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              uncache_i,
  input  logic              secure_i,
  input  logic              fwd_i,
  input  logic              fill_alloc_i,
  input  logic              first_wr_i,
  input  logic              first_upg_i,
  input  logic              svc_i,
  input  logic              svc_pmod_i,
  input  logic              fill_i,
  input  logic              snp_inv_i,
  input  logic              snp_rd_i,
  input  logic              dpend_set_i,
  input  logic              dpend_clr_i,
  input  logic              add_main_i,
  input  logic              add_wr_i,
  input  logic              add_upg_i,
  input  logic              promote_i,
  input  logic              prom_wr_i,
  input  logic              prom_upg_i,
  output entry_flags_t      flags_o,
  output logic [ADDR_W-1:0] addr_o
);
  entry_flags_t      f_q, f_n;
  logic [ADDR_W-1:0] addr_q, addr_n;

  always_comb begin
    f_n    = f_q;
    addr_n = addr_q;
    if (dealloc_i) begin
      f_n = '0;
    end else if (alloc_i) begin
      f_n            = '0;
      f_n.valid      = 1'b1;
      f_n.uncache    = uncache_i;
      f_n.secure     = secure_i;
      f_n.fwd        = fwd_i;
      f_n.fill_alloc = fill_alloc_i;
      f_n.need_wr    = first_wr_i;
      f_n.has_upg    = first_upg_i;
      addr_n         = addr_i;
    end else if (f_q.valid) begin
      if (svc_i && !f_q.in_service) begin
        f_n.in_service = 1'b1;
        f_n.pend_mod   = f_q.need_wr | svc_pmod_i;
      end
      if (f_q.in_service && snp_inv_i) f_n.post_inv = 1'b1;
      if (f_q.in_service && snp_rd_i)  f_n.post_dg  = 1'b1;
      if (fill_i && f_q.in_service) begin
        f_n.in_service = 1'b0;
        f_n.post_inv   = 1'b0;
        f_n.post_dg    = 1'b0;
      end
      if (dpend_set_i)      f_n.dpend = 1'b1;
      else if (dpend_clr_i) f_n.dpend = 1'b0;
      if (add_main_i) begin
        f_n.need_wr = f_q.need_wr | add_wr_i;
        f_n.has_upg = f_q.has_upg | add_upg_i;
      end
      if (promote_i) begin
        f_n.need_wr = prom_wr_i;
        f_n.has_upg = prom_upg_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= '0;
      addr_q <= '0;
    end else begin
      f_q    <= f_n;
      addr_q <= addr_n;
    end
  end

  assign flags_o = f_q;
  assign addr_o  = addr_q;

  assert_post_inv_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_q.post_inv) |-> $past(f_q.in_service));

  assert_post_dg_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_q.post_dg) |-> $past(f_q.in_service));

  assert_fill_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && f_q.in_service && !dealloc_i && !alloc_i) |=> !f_q.in_service);
endmodule

// File: rtl/miss_track_entry.sv
module miss_track_entry
  import miss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_uncache_i,
  input  logic              alloc_secure_i,
  input  logic              alloc_fwd_i,
  input  logic              alloc_fill_i,
  input  logic              tgt_add_i,
  input  logic [1:0]        tgt_src_i,
  input  logic [ORD_W-1:0]  tgt_order_i,
  input  logic [TIME_W-1:0] tgt_ready_i,
  input  logic              tgt_marked_i,
  input  logic              tgt_need_wr_i,
  input  logic              tgt_upgrade_i,
  input  logic              tgt_need_resp_i,
  input  logic              svc_i,
  input  logic              svc_pmod_i,
  input  logic              fill_i,
  input  logic              snp_inv_i,
  input  logic              snp_rd_i,
  input  logic              dpend_set_i,
  input  logic              dpend_clr_i,
  input  logic              pop_i,
  input  logic              promote_i,
  input  logic              dealloc_i,
  input  logic              flag_rd_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              uncache_o,
  output logic              secure_o,
  output logic              fwd_o,
  output logic              fill_alloc_o,
  output logic              in_service_o,
  output logic              dpend_o,
  output logic              need_wr_o,
  output logic              has_upg_o,
  output logic              pend_mod_o,
  output logic              post_inv_o,
  output logic              post_dg_o,
  output logic              flag_err_o,
  output logic              stall_o,
  output logic [CW-1:0]     main_cnt_o,
  output logic [CW-1:0]     def_cnt_o,
  output logic [CW:0]       num_tgt_o,
  output logic              fwd_nores_o,
  output logic [1:0]        head_src_o,
  output logic [ORD_W-1:0]  head_order_o,
  output logic [TIME_W-1:0] head_ready_o,
  output logic              head_marked_o,
  output logic              head_need_wr_o
);
  entry_flags_t  fl;
  tgt_t          new_tgt;
  tgt_t          main_arr [DEPTH];
  tgt_t          def_arr  [DEPTH];
  logic [CW-1:0] main_cnt, def_cnt;
  logic          main_full, main_empty, def_full, def_empty;
  logic          busy, do_alloc, do_dealloc, do_promote, sel_pop, sel_add;
  logic          to_def, push_main, push_def, prom_wr, prom_upg;

  assign new_tgt = '{src: tgt_src_e'(tgt_src_i), order: tgt_order_i, ready: tgt_ready_i,
                     marked: tgt_marked_i, need_wr: tgt_need_wr_i,
                     upgrade: tgt_upgrade_i, need_resp: tgt_need_resp_i};

  // one list operation per cycle: dealloc > alloc > promote > pop > add
  always_comb begin
    do_dealloc = dealloc_i & fl.valid;
    do_alloc   = alloc_i & ~dealloc_i & ~fl.valid;
    busy       = dealloc_i | alloc_i;
    do_promote = promote_i & ~busy & fl.valid & ~fl.in_service & main_empty & ~def_empty;
    sel_pop    = pop_i & ~busy & ~promote_i & fl.valid;
    sel_add    = tgt_add_i & ~busy & ~promote_i & ~pop_i & fl.valid;
    to_def     = fl.in_service & tgt_need_wr_i & ~fl.pend_mod;
    stall_o    = sel_add & (to_def ? def_full : main_full);
    push_main  = do_alloc | (sel_add & ~to_def & ~main_full);
    push_def   = sel_add & to_def & ~def_full;
  end

  always_comb begin
    prom_wr  = 1'b0;
    prom_upg = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < def_cnt) begin
        prom_wr  = prom_wr  | def_arr[i].need_wr;
        prom_upg = prom_upg | def_arr[i].upgrade;
      end
    end
  end

  miss_flag_ctl #(.ADDR_W(ADDR_W)) u_flags (
    .clk, .rst_n,
    .dealloc_i   (do_dealloc),
    .alloc_i     (do_alloc),
    .addr_i      (alloc_addr_i),
    .uncache_i   (alloc_uncache_i),
    .secure_i    (alloc_secure_i),
    .fwd_i       (alloc_fwd_i),
    .fill_alloc_i(alloc_fill_i),
    .first_wr_i  (tgt_need_wr_i),
    .first_upg_i (tgt_upgrade_i),
    .svc_i       (svc_i & ~busy),
    .svc_pmod_i  (svc_pmod_i),
    .fill_i      (fill_i & ~busy),
    .snp_inv_i   (snp_inv_i & ~busy),
    .snp_rd_i    (snp_rd_i & ~busy),
    .dpend_set_i (dpend_set_i & ~busy),
    .dpend_clr_i (dpend_clr_i & ~busy),
    .add_main_i  (push_main & ~do_alloc),
    .add_wr_i    (tgt_need_wr_i),
    .add_upg_i   (tgt_upgrade_i),
    .promote_i   (do_promote),
    .prom_wr_i   (prom_wr),
    .prom_upg_i  (prom_upg),
    .flags_o     (fl),
    .addr_o      (addr_o)
  );

  miss_tgt_fifo #(.DEPTH(DEPTH), .CW(CW)) u_main (
    .clk, .rst_n,
    .flush_i   (do_dealloc | do_alloc),
    .push_i    (push_main),
    .push_d_i  (new_tgt),
    .pop_i     (sel_pop),
    .load_i    (do_promote),
    .load_arr_i(def_arr),
    .load_cnt_i(def_cnt),
    .arr_o     (main_arr),
    .cnt_o     (main_cnt),
    .full_o    (main_full),
    .empty_o   (main_empty)
  );

  miss_tgt_fifo #(.DEPTH(DEPTH), .CW(CW)) u_defer (
    .clk, .rst_n,
    .flush_i   (do_dealloc | do_alloc | do_promote),
    .push_i    (push_def),
    .push_d_i  (new_tgt),
    .pop_i     (1'b0),
    .load_i    (1'b0),
    .load_arr_i(def_arr),
    .load_cnt_i(def_cnt),
    .arr_o     (def_arr),
    .cnt_o     (def_cnt),
    .full_o    (def_full),
    .empty_o   (def_empty)
  );

  assign valid_o        = fl.valid;
  assign uncache_o      = fl.uncache;
  assign secure_o       = fl.secure;
  assign fwd_o          = fl.fwd;
  assign fill_alloc_o   = fl.fill_alloc;
  assign in_service_o   = fl.in_service;
  assign dpend_o        = fl.dpend;
  assign need_wr_o      = fl.need_wr;
  assign has_upg_o      = fl.has_upg;
  assign pend_mod_o     = fl.pend_mod;
  assign post_inv_o     = fl.post_inv;
  assign post_dg_o      = fl.post_dg;
  assign flag_err_o     = flag_rd_i & ~fl.in_service;
  assign main_cnt_o     = main_cnt;
  assign def_cnt_o      = def_cnt;
  assign num_tgt_o      = {1'b0, main_cnt} + {1'b0, def_cnt};
  assign head_src_o     = main_arr[0].src;
  assign head_order_o   = main_arr[0].order;
  assign head_ready_o   = main_arr[0].ready;
  assign head_marked_o  = main_arr[0].marked;
  assign head_need_wr_o = main_arr[0].need_wr;
  assign fwd_nores_o    = (num_tgt_o == (CW+1)'(1)) && (main_cnt == CW'(1)) &&
                          (main_arr[0].src == SRC_CPU) && !main_arr[0].need_resp;

  assert_defer_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_add && to_def && !def_full) |=> (def_cnt == $past(def_cnt) + CW'(1)));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> $stable(num_tgt_o));

  assert_promote_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_promote |=> (main_cnt == $past(def_cnt)) && (def_cnt == '0));

  assert_no_defer_unserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (def_cnt != '0) |-> fl.valid);
endmodule

// File: tb/sim_miss_track_entry.sv
module sim_miss_track_entry;
  import miss_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DEPTH  = 8;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_i = 0, alloc_uncache_i = 0, alloc_secure_i = 0, alloc_fwd_i = 0, alloc_fill_i = 0;
  logic [ADDR_W-1:0] alloc_addr_i = '0;
  logic tgt_add_i = 0, tgt_marked_i = 0, tgt_need_wr_i = 0, tgt_upgrade_i = 0, tgt_need_resp_i = 0;
  logic [1:0] tgt_src_i = '0;
  logic [ORD_W-1:0] tgt_order_i = '0;
  logic [TIME_W-1:0] tgt_ready_i = '0;
  logic svc_i = 0, svc_pmod_i = 0, fill_i = 0, snp_inv_i = 0, snp_rd_i = 0;
  logic dpend_set_i = 0, dpend_clr_i = 0, pop_i = 0, promote_i = 0, dealloc_i = 0, flag_rd_i = 0;
  logic valid_o, uncache_o, secure_o, fwd_o, fill_alloc_o, in_service_o, dpend_o;
  logic need_wr_o, has_upg_o, pend_mod_o, post_inv_o, post_dg_o, flag_err_o, stall_o;
  logic [ADDR_W-1:0] addr_o;
  logic [CW-1:0] main_cnt_o, def_cnt_o;
  logic [CW:0] num_tgt_o;
  logic fwd_nores_o, head_marked_o, head_need_wr_o;
  logic [1:0] head_src_o;
  logic [ORD_W-1:0] head_order_o;
  logic [TIME_W-1:0] head_ready_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int main_q[$];
  int def_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_track_entry #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: predicts the destination list and records the order number
  task automatic add_tgt(input int src, input int ord, input bit wr, input bit upg,
                         input bit resp, input bit dest_def, input bit exp_stall);
    tgt_src_i = src[1:0]; tgt_order_i = ord[ORD_W-1:0]; tgt_need_wr_i = wr;
    tgt_upgrade_i = upg; tgt_need_resp_i = resp; tgt_ready_i = TIME_W'(ord + 100);
    tgt_add_i = 1;
    #1;
    if (exp_stall) chk("R11 stall", stall_o, 1);
    tick();
    tgt_add_i = 0; tgt_need_wr_i = 0; tgt_upgrade_i = 0; tgt_need_resp_i = 0;
    if (!exp_stall) begin
      if (dest_def) def_q.push_back(ord);
      else          main_q.push_back(ord);
    end
  endtask

  // monitor: compares the head with the predicted front, then pops
  task automatic pop_tgt();
    int exp_o;
    exp_o = main_q.pop_front();
    chk("R3 head order", 32'(head_order_o), exp_o);
    pop_i = 1;
    tick();
    pop_i = 0;
  endtask

  task automatic strobe(ref logic s);
    s = 1;
    tick();
    s = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1 valid", valid_o, 0);
    chk("R1 count", num_tgt_o, 0);
    chk("R1 in_service", in_service_o, 0);
    chk("R1 stall", stall_o, 0);

    // allocate with a CPU target needing no response
    alloc_addr_i = 32'h1000_0040; alloc_secure_i = 1; alloc_fill_i = 1;
    tgt_src_i = 0; tgt_order_i = 1; tgt_ready_i = 7; tgt_marked_i = 1;
    alloc_i = 1;
    tick();
    alloc_i = 0; tgt_marked_i = 0;
    main_q.push_back(1);
    chk("R2 valid", valid_o, 1);
    chk("R2 addr", addr_o, 32'h1000_0040);
    chk("R2 secure", secure_o, 1);
    chk("R2 fill_alloc", fill_alloc_o, 1);
    chk("R2 uncache", uncache_o, 0);
    chk("R2 ready", 32'(head_ready_o), 7);
    chk("R2 marked", head_marked_o, 1);
    chk("R2 need_wr", need_wr_o, 0);
    chk("R9 fwd_nores single", fwd_nores_o, 1);

    flag_rd_i = 1; #1;
    chk("R7 err out of service", flag_err_o, 1);
    flag_rd_i = 0;

    add_tgt(1, 2, 0, 1, 1, 0, 0);
    chk("R3 has_upg", has_upg_o, 1);
    chk("R8 count", num_tgt_o, 2);
    chk("R9 fwd_nores two", fwd_nores_o, 0);

    strobe(snp_inv_i);
    svc_pmod_i = 0; strobe(svc_i);
    chk("R6 snoop ignored", post_inv_o, 0);
    chk("R5 in_service", in_service_o, 1);
    chk("R5 pend_mod", pend_mod_o, 0);
    flag_rd_i = 1; #1;
    chk("R7 err in service", flag_err_o, 0);
    flag_rd_i = 0;

    add_tgt(0, 3, 1, 0, 1, 1, 0);
    chk("R4 deferred", def_cnt_o, 1);
    chk("R4 need_wr kept", need_wr_o, 0);
    add_tgt(2, 4, 0, 0, 1, 0, 0);
    chk("R4 main", main_cnt_o, 3);
    chk("R8 sum", num_tgt_o, 4);

    snp_inv_i = 1; snp_rd_i = 1;
    tick();
    snp_inv_i = 0; snp_rd_i = 0;
    chk("R6 post_inv", post_inv_o, 1);
    chk("R6 post_dg", post_dg_o, 1);

    strobe(fill_i);
    chk("R13 fill", in_service_o, 0);
    chk("R6 fill clears", post_inv_o, 0);

    strobe(promote_i);
    chk("R10 ignored def", def_cnt_o, 1);
    chk("R10 ignored main", main_cnt_o, 3);

    for (int k = 0; k < 3; k++) pop_tgt();
    chk("R3 drained", main_cnt_o, 0);

    strobe(promote_i);
    foreach (def_q[k]) main_q.push_back(def_q[k]);
    def_q.delete();
    chk("R10 main", main_cnt_o, 1);
    chk("R10 def", def_cnt_o, 0);
    chk("R10 need_wr", need_wr_o, 1);
    chk("R10 head", 32'(head_order_o), 3);

    svc_pmod_i = 0; strobe(svc_i);
    chk("R5 pend_mod from need_wr", pend_mod_o, 1);
    add_tgt(0, 5, 1, 0, 1, 0, 0);
    chk("R4 write to main", main_cnt_o, 2);
    for (int k = 6; k < 12; k++) add_tgt(2, k, 0, 0, 1, 0, 0);
    chk("R11 full", main_cnt_o, 8);
    add_tgt(2, 12, 0, 0, 1, 0, 1);
    chk("R11 unchanged", num_tgt_o, 8);

    strobe(dpend_set_i);
    chk("R12 dpend set", dpend_o, 1);
    strobe(dpend_clr_i);
    chk("R12 dpend clr", dpend_o, 0);

    for (int k = 0; k < 8; k++) pop_tgt();

    strobe(dealloc_i);
    chk("R12 dealloc valid", valid_o, 0);
    chk("R12 dealloc count", num_tgt_o, 0);
    chk("R12 dealloc svc", in_service_o, 0);

    // pending-modified promised by the fill
    alloc_addr_i = 32'h2000_0080; tgt_src_i = 0; tgt_order_i = 20; tgt_need_wr_i = 0;
    alloc_i = 1;
    tick();
    alloc_i = 0;
    main_q.push_back(20);
    svc_pmod_i = 1; strobe(svc_i); svc_pmod_i = 0;
    chk("R5 pend_mod input", pend_mod_o, 1);
    add_tgt(0, 21, 1, 0, 1, 0, 0);
    chk("R4 promised main", main_cnt_o, 2);
    chk("R4 promised def", def_cnt_o, 0);
    chk("R3 need_wr or", need_wr_o, 1);
    pop_tgt();
    pop_tgt();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule